// File: doc/BRIEF.md
# Monitor interrupt aggregation controller

This block collects out-of-limit indications from a hardware monitor and drives a single active-low interrupt line. Limit-comparison flags arrive for each temperature zone, each voltage channel and each fan tachometer. Every flag sets a sticky status bit. Software reads the status bits through a small register port, and a read clears them. Three class enables choose which classes may drive the line. A global enable and a pin-function enable gate the line as a whole.

A remote diode fault never drives the line by itself. It replaces that zone's reading with the fixed code 0x80 and raises the zone's error bit, and that error bit can then assert the line if temperature events are enabled. An alert-response pulse releases the line. The line also stays released while the monitor is in a low-power state, and no new status is captured in that state. Software can re-arm the line by writing the global enable from 0 back to 1.

Top module: `mon_irq_agg`

## Requirements
- R1: While `mon_active` is 1, a status bit sets on every cycle its stimulus is high, whatever the enables hold. Flat status order: temperature zones at bits 0..NTEMP-1, then voltages, then fans. With the defaults this gives temp 0..2 = bits 0..2, volt 0..13 = bits 3..16 and fan 0..3 = bits 17..20. Status register k (address k, k = 0..2) holds flat bits 8k+7..8k.
- R2: `int_n` is 0 exactly when all of the following hold: pin-function is 1, global enable is 1, `mon_active` is 1, no alert hold is in force, and some set status bit belongs to an enabled class. The line follows the clock edge at which the state changes.
- R3: Control register (address 4) holds the class enables: bit 2 enables voltages, bit 3 enables temperatures, bit 4 enables fans. A set status bit in a disabled class leaves `int_n` at 1.
- R4: Control bit 0 (pin function) and control bit 1 (global enable) must both be 1 for `int_n` to assert.
- R5: A read of addresses 0..3 returns the register in `rdata` one cycle after `rd_en`. It then clears every bit of that register whose stimulus is inactive at the read edge. Bits whose stimulus is still active stay set.
- R6: A diode fault on a zone forces `zone_temp_out` for that zone to 0x80. It sets that zone's temperature status bit and its bit in the fault register (address 3, bit z). It asserts `int_n` only through the zone bit and the temperature enable.
- R7: An `ara_pulse` releases `int_n` from the next edge. The line stays released until a status bit newly sets or the global enable is written from 0 to 1.
- R8: While `mon_active` is 0, `int_n` is 1 and no status bit newly sets. Bits already set are kept.
- R9: Clearing the global enable, reading status while a stimulus is still active, and then writing the global enable back to 1 asserts `int_n` again.
- R10: After reset all status, fault and control bits read 0 and `int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mon_active | input | 1 | 1 = monitor operational, 0 = low power |
| temp_oor | input | NTEMP | Temperature zone out-of-limit flags |
| diode_fault | input | NTEMP | Remote diode fault flags |
| zone_temp_in | input | 8*NTEMP | Zone readings from the converter |
| zone_temp_out | output | 8*NTEMP | Zone readings, 0x80 on a faulted zone |
| volt_oor | input | NVOLT | Voltage out-of-limit flags |
| fan_err | input | NFAN | Fan tachometer error flags |
| ara_pulse | input | 1 | Alert-response deassert pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench reads status while a stimulus is still held. A design that cleared unconditionally would lose the event and break the re-arm sequence. It raises a diode fault with the temperature class disabled and the other classes enabled, which exposes a fault wired straight to the line. It holds a stimulus across an alert pulse and then adds a new event or toggles the global enable; a design that re-asserted at once, or never, shows up here. It also pulses a stimulus during low power, which catches a design that captures status or drives the line while asleep.

// File: rtl/mon_irq_agg.sv
module mon_irq_agg #(
  parameter int NTEMP = 3,
  parameter int NVOLT = 14,
  parameter int NFAN  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mon_active,
  input  logic [NTEMP-1:0]     temp_oor,
  input  logic [NTEMP-1:0]     diode_fault,
  input  logic [8*NTEMP-1:0]   zone_temp_in,
  output logic [8*NTEMP-1:0]   zone_temp_out,
  input  logic [NVOLT-1:0]     volt_oor,
  input  logic [NFAN-1:0]      fan_err,
  input  logic                 ara_pulse,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [2:0]           addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata
  ,output logic                int_n
);
  localparam int NEV  = NTEMP + NVOLT + NFAN;
  localparam int SW   = 24;
  localparam int PAD  = SW - NEV;

  logic [SW-1:0]    stat, stim, en_mask, clr_mask;
  logic [NTEMP-1:0] flt, flt_stim;
  logic pin_fn, gie, volt_en, temp_en, fan_en, ara_hold;
  logic ctrl_wr, gie_rise, new_set;

  for (genvar z = 0; z < NTEMP; z++) begin : g_zone
    assign zone_temp_out[8*z +: 8] = diode_fault[z] ? 8'h80 : zone_temp_in[8*z +: 8];
  end

  assign stim     = mon_active ? {{PAD{1'b0}}, fan_err, volt_oor, temp_oor | diode_fault} : '0;
  assign flt_stim = mon_active ? diode_fault : '0;
  assign en_mask  = {{PAD{1'b0}}, {NFAN{fan_en}}, {NVOLT{volt_en}}, {NTEMP{temp_en}}};
  assign clr_mask = !rd_en ? '0 :
                    addr == 3'd0 ? SW'(24'h0000FF) :
                    addr == 3'd1 ? SW'(24'h00FF00) :
                    addr == 3'd2 ? SW'(24'hFF0000) : '0;
  assign ctrl_wr  = wr_en && addr == 3'd4;
  assign gie_rise = ctrl_wr && wdata[1] && !gie;
  assign new_set  = |(stim & ~stat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      flt  <= '0;
      {fan_en, temp_en, volt_en, gie, pin_fn} <= '0;
      ara_hold <= 1'b0;
      rdata <= '0;
    end else begin
      stat <= (stat & ~clr_mask) | stim;
      flt  <= ((rd_en && addr == 3'd3) ? '0 : flt) | flt_stim;
      if (ctrl_wr) {fan_en, temp_en, volt_en, gie, pin_fn} <= wdata[4:0];
      if (ara_pulse) ara_hold <= 1'b1;
      else if (new_set || gie_rise) ara_hold <= 1'b0;
      if (rd_en) begin
        case (addr)
          3'd0: rdata <= stat[7:0];
          3'd1: rdata <= stat[15:8];
          3'd2: rdata <= stat[23:16];
          3'd3: rdata <= 8'(flt);
          3'd4: rdata <= {3'b000, fan_en, temp_en, volt_en, gie, pin_fn};
          default: rdata <= 8'h00;
        endcase
      end
    end
  end

  assign int_n = !(pin_fn && gie && mon_active && !ara_hold && |(stat & en_mask));

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_active |-> int_n);
  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie || !pin_fn) |-> int_n);
  // R7
  ara_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ara_pulse |=> int_n);
  // R1
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stim) |=> ((stat & $past(stim)) == $past(stim)));
  // R6
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diode_fault[0] |-> zone_temp_out[7:0] == 8'h80);
endmodule

// File: tb/tb_mon_irq_agg.sv
module tb_mon_irq_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NTEMP = 3, NVOLT = 14, NFAN = 4;

  logic clk = 0, rst_n = 0, mon_active = 0, ara_pulse = 0;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [NTEMP-1:0] temp_oor = 0, diode_fault = 0;
  logic [8*NTEMP-1:0] zone_temp_in = {3{8'h19}}, zone_temp_out;
  logic [NVOLT-1:0] volt_oor = 0;
  logic [NFAN-1:0] fan_err = 0;
  logic int_n;
  int n_tests = 0, n_fail = 0, cyc = 0;
  logic rd_pend = 0;
  int exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_irq_agg #(.NTEMP(NTEMP), .NVOLT(NVOLT), .NFAN(NFAN)) dut (
    .clk(clk), .rst_n(rst_n), .mon_active(mon_active), .temp_oor(temp_oor),
    .diode_fault(diode_fault), .zone_temp_in(zone_temp_in), .zone_temp_out(zone_temp_out),
    .volt_oor(volt_oor), .fan_err(fan_err), .ara_pulse(ara_pulse), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .int_n(int_n));

  always @(posedge clk) begin
    rd_pend <= rd_en;
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (rdata !== e[7:0]) begin
        n_fail++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e[7:0]);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; rd_en = 1;
    exp_q.push_back(int'(e)); tag_q.push_back(t);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic chk_pin(input logic e, input string t);
    #1;
    n_tests++;
    if (int_n !== e) begin
      n_fail++;
      $display("FAIL %s: int_n actual %b expected %b", t, int_n, e);
    end
  endtask

  initial begin
    tick(3);
    chk_pin(1'b1, "R10 reset pin");
    rst_n = 1; mon_active = 1;
    tick(1);
    chk_pin(1'b1, "R10 pin after reset");
    rd(3'd4, 8'h00, "R10 ctrl reset");
    rd(3'd0, 8'h00, "R10 status0 reset");
    rd(3'd3, 8'h00, "R10 fault reset");

    // R1 R2: temp zone 1 pulse, all enabled
    wr(3'd4, 8'h1F);
    rd(3'd4, 8'h1F, "R3 ctrl readback");
    temp_oor[1] = 1; tick(1); temp_oor[1] = 0;
    chk_pin(1'b0, "R2 temp event asserts");
    rd(3'd0, 8'h02, "R1 temp bit sticky");
    chk_pin(1'b1, "R5 pin releases after clear");
    rd(3'd0, 8'h00, "R5 cleared");

    // R3: voltage class disabled
    wr(3'd4, 8'h1B);
    volt_oor[0] = 1; tick(1); volt_oor[0] = 0;
    chk_pin(1'b1, "R3 volt class off");
    wr(3'd4, 8'h1F);
    chk_pin(1'b0, "R3 volt class on");
    rd(3'd0, 8'h08, "R1 volt bit set while disabled");
    chk_pin(1'b1, "R5 volt cleared");

    // R5: read while stimulus active
    fan_err[2] = 1; tick(1);
    rd(3'd2, 8'h08, "R5 fan read 1");
    rd(3'd2, 8'h08, "R5 fan kept while active");
    fan_err[2] = 0;
    rd(3'd2, 8'h08, "R5 fan still latched");
    rd(3'd2, 8'h00, "R5 fan cleared");

    // R6: diode fault, temp class disabled
    wr(3'd4, 8'h17);
    diode_fault[0] = 1; tick(2);
    chk_pin(1'b1, "R6 fault not direct");
    n_tests++;
    if (zone_temp_out !== {8'h19, 8'h19, 8'h80}) begin
      n_fail++;
      $display("FAIL R6: zone_temp_out actual %06h expected %06h", zone_temp_out, 24'h191980);
    end
    rd(3'd3, 8'h01, "R6 fault reg");
    wr(3'd4, 8'h1F);
    chk_pin(1'b0, "R6 zone error asserts");
    diode_fault[0] = 0; tick(1);
    rd(3'd0, 8'h01, "R6 zone bit");
    rd(3'd3, 8'h01, "R6 fault latched");
    rd(3'd3, 8'h00, "R6 fault cleared");
    chk_pin(1'b1, "R6 released");

    // R4: global and pin-function gates
    volt_oor[13] = 1; tick(1);
    chk_pin(1'b0, "R2 volt13 asserts");
    wr(3'd4, 8'h1D);
    chk_pin(1'b1, "R4 gie off");
    wr(3'd4, 8'h1E);
    chk_pin(1'b1, "R4 pin fn off");
    wr(3'd4, 8'h1F);
    chk_pin(1'b0, "R4 both on");

    // R7: alert response
    @(negedge clk); ara_pulse = 1; @(negedge clk); ara_pulse = 0;
    chk_pin(1'b1, "R7 ara releases");
    tick(3);
    chk_pin(1'b1, "R7 stays released");
    fan_err[0] = 1; tick(1);
    chk_pin(1'b0, "R7 new bit reasserts");
    @(negedge clk); ara_pulse = 1; @(negedge clk); ara_pulse = 0;
    chk_pin(1'b1, "R7 second ara");
    wr(3'd4, 8'h1D);
    wr(3'd4, 8'h1F);
    chk_pin(1'b0, "R7 gie rewrite rearms");

    // R9: re-arm sequence with stimulus still active
    wr(3'd4, 8'h1D);
    rd(3'd2, 8'h03, "R9 status kept");
    wr(3'd4, 8'h1F);
    chk_pin(1'b0, "R9 reasserts");
    volt_oor[13] = 0; fan_err[0] = 0; tick(1);
    rd(3'd2, 8'h03, "R9 latched");
    rd(3'd2, 8'h00, "R9 cleared");
    chk_pin(1'b1, "R9 released");

    // R8: low power
    temp_oor[0] = 1; tick(1); temp_oor[0] = 0;
    chk_pin(1'b0, "R8 pending before sleep");
    mon_active = 0;
    chk_pin(1'b1, "R8 sleep holds pin");
    temp_oor[2] = 1; tick(1); temp_oor[2] = 0; tick(1);
    mon_active = 1;
    chk_pin(1'b0, "R8 wake reasserts");
    rd(3'd0, 8'h01, "R8 no capture in sleep");
    rd(3'd0, 8'h00, "R8 cleared");

    tick(3);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule